// File: doc/BRIEF.md
# Polled Byte Device Controller

This block sits between a host register bus and a byte-wide device port. The host works through four registers at fixed word offsets. It reads a status word until the busy bit is clear, loads an output byte, and writes a command word with its start bit set. The controller then takes ownership. It raises busy, decodes the command and moves one byte over the device port: out of the output register for a send, or into the input register for a receive. It retires the command in a fixed order that the host can see by polling.

A command that asks for neither direction, or for both, is refused. The refusal is reported through a sticky error flag, and the command goes through the same retirement sequence. The device side uses a valid/ready byte handshake in each direction, and the controller stays busy for as long as the device stalls.

Top module: `mmdc_ctrl`

## Requirements
- R1: After reset every register reads zero, busy, error and byte-waiting are clear, and neither device strobe (`dev_tx_valid`, `dev_rx_ready`) is asserted.
- R2: The register map decodes the low address bits as follows: 0x0 input byte (read only), 0x4 output byte (read/write), 0x8 status, 0xC command. Status bits: bit0 busy, bit1 error, bit2 byte-waiting. Command bits: bit0 send, bit1 receive, bit2 start. Any other address reads zero, and writing the command with start clear launches nothing.
- R3: Busy rises on the clock edge after the edge that stores a command with start set. No device strobe is asserted in the first cycle of busy, and a strobe is only ever asserted while busy is high.
- R4: A send command (send=1, receive=0) holds `dev_tx_valid` with the output byte, stable, until `dev_tx_ready`. Each send delivers exactly one byte.
- R5: A receive command (receive=1, send=0) holds `dev_rx_ready` until `dev_rx_valid`, stores `dev_rx_data` as the input byte and sets byte-waiting.
- R6: A host read of the input register clears byte-waiting. It does not change the stored byte.
- R7: On successful completion, start and error clear on the same edge, and busy clears on the following edge. For a send whose device accepts after w stall cycles, start clears 4+w cycles and busy clears 5+w cycles after the command-write edge.
- R8: A command whose send and receive bits are equal sets error and clears start. Busy clears one edge later, 4 cycles after the command-write edge. No device strobe is asserted, and the send/receive bits are left as written.
- R9: Host writes to the output and command registers have no effect while busy is set.
- R10: Error stays set across later register traffic until a command completes successfully.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| dev_tx_valid | output | 1 | Output byte offered to the device |
| dev_tx_ready | input | 1 | Device takes the offered byte |
| dev_tx_data | output | DATA_W | Byte offered to the device |
| dev_rx_valid | input | 1 | Device offers an input byte |
| dev_rx_ready | output | 1 | Controller will take an input byte |
| dev_rx_data | input | DATA_W | Byte from the device |

## Verification
The assertions take for granted that the host follows the polling discipline. It writes a new command only after it has read busy clear, and it does not rewrite the command register in the single cycle between storing start and busy rising. The device side may stall each handshake for any number of cycles but must not drop a byte it has offered. The stimulus keeps to these rules: each command is launched from an idle controller, any write made while busy is delayed one cycle so that busy is already set when it lands, and the device models raise their valid or ready only after a programmed stall count.

// File: rtl/mmdc_pkg.sv
// Shared constants and types for the polled byte device controller.
// Assumes byte-addressed registers on word offsets and DATA_W >= 3.
package mmdc_pkg;

    localparam int OFF_DIN  = 0;
    localparam int OFF_DOUT = 4;
    localparam int OFF_STAT = 8;
    localparam int OFF_CMD  = 12;

    localparam int ST_BUSY  = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_AVAIL = 2;

    localparam int CMD_BITS = 3;

    // Command word: start is bit2, receive bit1, send bit0.
    typedef struct packed {
        logic go;
        logic rd;
        logic wr;
    } cmd_t;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_DECODE,
        HS_SEND,
        HS_RECV,
        HS_BAD,
        HS_FINISH,
        HS_CLOSE
    } hs_state_e;

endpackage

// File: rtl/mmdc_regs.sv
// Host-visible register file: decodes the bus, holds the output byte,
// command word, input byte, error and byte-waiting flags.
// Assumes the handshake engine drives at most one of set_err/clr_err.
module mmdc_regs
    import mmdc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              clr_go,
    input  logic              set_err,
    input  logic              clr_err,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output cmd_t              cmd_q,
    output logic [DATA_W-1:0] dout_q
);

    logic              hit_din, hit_dout, hit_stat, hit_cmd;
    logic              wr_ok, rd_din;
    logic [DATA_W-1:0] din_q;
    logic              err_q, avail_q;

    // Address decode and access qualifiers.
    always_comb begin
        hit_din  = (bus_addr == ADDR_W'(OFF_DIN));
        hit_dout = (bus_addr == ADDR_W'(OFF_DOUT));
        hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
        hit_cmd  = (bus_addr == ADDR_W'(OFF_CMD));
        wr_ok    = bus_sel && bus_wr && !busy;
        rd_din   = bus_sel && !bus_wr && hit_din;
    end

    // Output byte register, frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (wr_ok && hit_dout)
            dout_q <= bus_wdata;
    end

    // Command word: host load when idle, start cleared by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_ok && hit_cmd)
            cmd_q <= cmd_t'(bus_wdata[CMD_BITS-1:0]);
        else if (clr_go)
            cmd_q.go <= 1'b0;
    end

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (set_err)
            err_q <= 1'b1;
        else if (clr_err)
            err_q <= 1'b0;
    end

    // Input byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            din_q <= '0;
        else if (cap_en)
            din_q <= cap_data;
    end

    // Byte-waiting flag: set by capture, cleared by a host read of the input byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            avail_q <= 1'b0;
        else if (cap_en)
            avail_q <= 1'b1;
        else if (rd_din)
            avail_q <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (hit_din) begin
            bus_rdata = din_q;
        end else if (hit_dout) begin
            bus_rdata = dout_q;
        end else if (hit_stat) begin
            bus_rdata[ST_BUSY]  = busy;
            bus_rdata[ST_ERR]   = err_q;
            bus_rdata[ST_AVAIL] = avail_q;
        end else if (hit_cmd) begin
            bus_rdata[CMD_BITS-1:0] = cmd_q;
        end
    end

endmodule

// File: rtl/mmdc_fsm.sv
// Command handshake engine: raises busy on a started command, decodes it,
// runs one device byte transfer and retires the command in a fixed order
// (start and error updated first, busy dropped on the next edge).
// Assumes the command word does not change while busy.
module mmdc_fsm
    import mmdc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd_q,
    input  logic              dev_tx_ready,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    output logic              busy,
    output logic              dev_tx_valid,
    output logic              dev_rx_ready,
    output logic              clr_go,
    output logic              set_err,
    output logic              clr_err,
    output logic              cap_en,
    output logic [DATA_W-1:0] cap_data
);

    hs_state_e state_q, state_d;
    logic      busy_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            HS_IDLE:   if (cmd_q.go) state_d = HS_DECODE;
            HS_DECODE: begin
                if (cmd_q.wr && !cmd_q.rd)
                    state_d = HS_SEND;
                else if (cmd_q.rd && !cmd_q.wr)
                    state_d = HS_RECV;
                else
                    state_d = HS_BAD;
            end
            HS_SEND:   if (dev_tx_ready) state_d = HS_FINISH;
            HS_RECV:   if (dev_rx_valid) state_d = HS_FINISH;
            HS_BAD:    state_d = HS_CLOSE;
            HS_FINISH: state_d = HS_CLOSE;
            HS_CLOSE:  state_d = HS_IDLE;
            default:   state_d = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= HS_IDLE;
        else
            state_q <= state_d;
    end

    // Busy flag: raised on command pickup, dropped as the last retirement step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (state_q == HS_IDLE && cmd_q.go)
            busy_q <= 1'b1;
        else if (state_q == HS_CLOSE)
            busy_q <= 1'b0;
    end

    // Device strobes and register-file controls decoded from state.
    always_comb begin
        busy         = busy_q;
        dev_tx_valid = (state_q == HS_SEND);
        dev_rx_ready = (state_q == HS_RECV);
        cap_en       = (state_q == HS_RECV) && dev_rx_valid;
        cap_data     = dev_rx_data;
        clr_go       = (state_q == HS_FINISH) || (state_q == HS_BAD);
        set_err      = (state_q == HS_BAD);
        clr_err      = (state_q == HS_FINISH);
    end

endmodule

// File: rtl/mmdc_ctrl.sv
// Top of the polled byte device controller: joins the register file and
// the handshake engine, and drives the device byte from the output register.
// Assumes a host that polls busy before issuing a command.
module mmdc_ctrl
    import mmdc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dev_tx_valid,
    input  logic              dev_tx_ready,
    output logic [DATA_W-1:0] dev_tx_data,
    input  logic              dev_rx_valid,
    output logic              dev_rx_ready,
    input  logic [DATA_W-1:0] dev_rx_data
);

    logic              busy_w;
    logic              clr_go, set_err, clr_err, cap_en;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] dout_q;
    cmd_t              cmd_q;

    mmdc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy_w),
        .clr_go    (clr_go),
        .set_err   (set_err),
        .clr_err   (clr_err),
        .cap_en    (cap_en),
        .cap_data  (cap_data),
        .cmd_q     (cmd_q),
        .dout_q    (dout_q)
    );

    mmdc_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_q        (cmd_q),
        .dev_tx_ready (dev_tx_ready),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_data  (dev_rx_data),
        .busy         (busy_w),
        .dev_tx_valid (dev_tx_valid),
        .dev_rx_ready (dev_rx_ready),
        .clr_go       (clr_go),
        .set_err      (set_err),
        .clr_err      (clr_err),
        .cap_en       (cap_en),
        .cap_data     (cap_data)
    );

    // Device output byte comes straight from the frozen output register.
    assign dev_tx_data = dout_q;

endmodule

// File: rtl/mmdc_ctrl_chk.sv
// Protocol checker for mmdc_ctrl, attached by bind. Observes busy, the
// command word and the output register alongside the device strobes.
module mmdc_ctrl_chk
    import mmdc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input cmd_t              cmd_q,
    input logic [DATA_W-1:0] dout_q,
    input logic              dev_tx_valid,
    input logic              dev_tx_ready,
    input logic [DATA_W-1:0] dev_tx_data,
    input logic              dev_rx_ready
);

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd_q.go);

    // R3
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid || dev_rx_ready) |-> busy);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data)));

    // R4
    one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_tx_valid && dev_rx_ready));

    // R7
    busy_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!cmd_q.go && $past(!cmd_q.go)));

    // R9
    dout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dout_q));

endmodule

bind mmdc_ctrl mmdc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy_w),
    .cmd_q        (cmd_q),
    .dout_q       (dout_q),
    .dev_tx_valid (dev_tx_valid),
    .dev_tx_ready (dev_tx_ready),
    .dev_tx_data  (dev_tx_data),
    .dev_rx_ready (dev_rx_ready)
);

// File: tb/mmdc_ctrl_tb.sv
// Scoreboard bench: send tasks queue expected device bytes, the device
// model pops and compares them on each accepted transfer.
module mmdc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       dev_tx_valid, dev_tx_ready = 1'b0;
    logic [7:0] dev_tx_data;
    logic       dev_rx_valid = 1'b0, dev_rx_ready;
    logic [7:0] dev_rx_data = '0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] tx_exp[$];
    int tx_wait = 0, tx_cnt = 0;
    int rx_wait = 0, rx_cnt = 0, rx_seen = 0;
    logic [7:0] rx_byte = '0;
    logic [7:0] rd1;
    logic tv1, tv2;

    mmdc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
        .dev_tx_data(dev_tx_data), .dev_rx_valid(dev_rx_valid),
        .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Device model: stall counts, then accept/offer; monitor pops the scoreboard.
    always @(negedge clk) begin
        if (dev_tx_valid) begin
            if (tx_cnt >= tx_wait) begin
                dev_tx_ready = 1'b1;
                tx_cnt = 0;
                n_chk++;
                if (tx_exp.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8 unexpected device byte: actual 0x%0h expected none", dev_tx_data);
                end else begin
                    logic [7:0] e;
                    e = tx_exp.pop_front();
                    if (dev_tx_data !== e) begin
                        n_fail++;
                        $display("FAIL R4 device byte: actual 0x%0h expected 0x%0h", dev_tx_data, e);
                    end
                end
            end else begin
                dev_tx_ready = 1'b0;
                tx_cnt++;
            end
        end else begin
            dev_tx_ready = 1'b0;
            tx_cnt = 0;
        end
        if (dev_rx_ready) begin
            rx_seen++;
            if (rx_cnt >= rx_wait) begin
                dev_rx_valid = 1'b1;
                dev_rx_data  = rx_byte;
                rx_cnt = 0;
            end else begin
                dev_rx_valid = 1'b0;
                rx_cnt++;
            end
        end else begin
            dev_rx_valid = 1'b0;
            rx_cnt = 0;
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Hold a read on one register and count cycles until bit b equals v.
    task automatic watch(input logic [3:0] a, input int b, input logic v,
                         input int from, output int idx);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        idx = -1;
        for (int i = 0; i < 200; i++) begin
            if (i == 1) begin rd1 = bus_rdata; tv1 = dev_tx_valid; end
            if (i == 2) tv2 = dev_tx_valid;
            if (i >= from && bus_rdata[b] == v) begin idx = i; break; end
            @(negedge clk); #1;
        end
        bus_sel = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        bus_write(4'h4, b);
        tx_exp.push_back(b);
        bus_write(4'hC, 8'h05);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int idx, rx_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", "tx_valid", dev_tx_valid, 0);
        chk("R1", "rx_ready", dev_rx_ready, 0);
        bus_read(4'h8, r); chk("R1", "status", r, 8'h00);
        bus_read(4'hC, r); chk("R1", "command", r, 8'h00);
        bus_read(4'h0, r); chk("R1", "input byte", r, 8'h00);
        bus_read(4'h4, r); chk("R1", "output byte", r, 8'h00);

        // R2 register map
        bus_write(4'h4, 8'hA5);
        bus_read(4'h4, r); chk("R2", "output readback", r, 8'hA5);
        bus_read(4'h2, r); chk("R2", "unmapped read", r, 8'h00);
        bus_write(4'hC, 8'h01);
        repeat (3) @(negedge clk);
        bus_read(4'hC, r); chk("R2", "command readback", r, 8'h01);
        bus_read(4'h8, r); chk("R2", "no launch without start", r, 8'h00);

        // R3/R7 send, no stall: busy clears 5 cycles after command edge
        tx_wait = 0;
        send_byte(8'h3C);
        watch(4'h8, 0, 1'b0, 1, idx);
        chk("R3", "busy in first cycle", rd1[0], 1);
        chk("R3", "no strobe in first busy cycle", tv1, 0);
        chk("R4", "tx_valid in second busy cycle", tv2, 1);
        chk("R7", "busy clear cycle w=0", idx, 5);
        bus_read(4'h8, r); chk("R7", "status after send", r, 8'h00);

        // R7 send with 3 stall cycles: start clears at 7, busy one later
        tx_wait = 3;
        send_byte(8'h81);
        watch(4'hC, 2, 1'b0, 0, idx);
        chk("R7", "start clear cycle w=3", idx, 7);
        watch(4'h8, 0, 1'b0, 0, idx);
        chk("R7", "busy clears one cycle after start", idx, 1);
        tx_wait = 0;

        // R8 invalid commands: neither and both directions
        rx_before = rx_seen;
        bus_write(4'hC, 8'h04);
        watch(4'h8, 0, 1'b0, 1, idx);
        chk("R8", "busy clear for empty command", idx, 4);
        bus_read(4'h8, r); chk("R8", "error set", r, 8'h02);
        bus_read(4'hC, r); chk("R8", "command after refusal", r, 8'h00);
        bus_write(4'hC, 8'h07);
        watch(4'h8, 0, 1'b0, 1, idx);
        chk("R8", "busy clear for dual command", idx, 4);
        bus_read(4'hC, r); chk("R8", "direction bits kept", r, 8'h03);
        chk("R8", "no receive strobe", rx_seen, rx_before);

        // R10 error survives register traffic, cleared by a good command
        bus_write(4'h4, 8'h5F);
        bus_read(4'h8, r); chk("R10", "error sticky", r, 8'h02);
        send_byte(8'h5F);
        watch(4'h8, 0, 1'b0, 1, idx);
        bus_read(4'h8, r); chk("R10", "error cleared by success", r, 8'h00);

        // R5/R6 receive with stall
        rx_wait = 2; rx_byte = 8'h5A;
        bus_write(4'hC, 8'h06);
        watch(4'h8, 0, 1'b0, 1, idx);
        bus_read(4'h8, r); chk("R5", "byte waiting", r, 8'h04);
        bus_read(4'h0, r); chk("R5", "input byte", r, 8'h5A);
        bus_read(4'h8, r); chk("R6", "waiting cleared by read", r, 8'h00);
        bus_read(4'h0, r); chk("R6", "input byte kept", r, 8'h5A);

        // R9 writes while busy are dropped
        tx_wait = 6;
        send_byte(8'h11);
        @(negedge clk);
        bus_write(4'h4, 8'hEE);
        bus_write(4'hC, 8'h06);
        watch(4'h8, 0, 1'b0, 0, idx);
        bus_read(4'h4, r); chk("R9", "output byte frozen", r, 8'h11);
        bus_read(4'hC, r); chk("R9", "command frozen", r, 8'h01);
        repeat (4) @(negedge clk);
        bus_read(4'h8, r); chk("R9", "no relaunch", r, 8'h00);

        // R4 every queued byte delivered exactly once
        chk("R4", "scoreboard drained", tx_exp.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule